// File: doc/BRIEF.md
# Event Timestamp Capture Buffer

This block keeps one captured time value per traffic direction. A free-running 64-bit time count enters as an input, and the packet parser that feeds the block raises a one-cycle event strobe together with a 16-bit sequence identifier. When a direction is enabled and its buffer is empty, the strobe freezes the current time and the sequence identifier into that direction's buffer. The buffer then sets a held flag. Software reads the flag and the frozen time, then writes the flag bit back as one to empty the buffer. Strobes that arrive while the buffer is full are dropped.

There are two identical lanes, receive and transmit. Each lane has four word registers behind a small register port: status, time low, time high and enable. Address bit 2 selects the lane (0 receive, 1 transmit), and address bits 1:0 select the register. Software reads the low time word first and the high word second. Because the held value cannot change until software empties the buffer, the two halves always belong to the same capture. Software empties both buffers whenever it changes the upstream filters or turns the feature on, so that it discards stale captures.

Top module: `ts_capture_pair`

## Requirements
- R1: After reset, every register of both lanes reads 0: the held flag is clear, the time words are zero and the enable field is zero.
- R2: While a lane's enable field (register 3, bits 2:0) is zero, event strobes on that lane leave its status and time registers unchanged.
- R3: When a lane's enable field is nonzero, its held flag is clear and its strobe is high, the buffer captures the time input and sequence input of that same cycle. From the next clock on, status bit 16 reads 1, status bits 15:0 read the sequence identifier, register 1 reads time bits 31:0 and register 2 reads time bits 63:32.
- R4: While the held flag is set, further strobes change neither the held time nor the sequence identifier.
- R5: A write to the status register (offset 0) with bit 16 set clears the held flag from the next clock on. A status write with bit 16 clear has no effect.
- R6: When a rearm write and a strobe fall in the same cycle, the result depends on the buffer. A full buffer is emptied and the strobe is dropped. An empty buffer captures the strobe, and the write has no effect.
- R7: The two lanes are independent. A strobe, rearm write or enable write on one lane leaves the other lane's registers unchanged.
- R8: The enable register keeps the 3 written bits and reads them back in bits 2:0, with the upper bits reading 0. Any nonzero value enables capture, starting with strobes in the cycle after the write.
- R9: Writes to the time registers (offsets 1 and 2) are ignored, and status bits 31:17 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current value of the time count |
| rx_evt | input | 1 | Receive-lane event strobe |
| rx_seq | input | 16 | Sequence identifier for the receive strobe |
| tx_evt | input | 1 | Transmit-lane event strobe |
| tx_seq | input | 16 | Sequence identifier for the transmit strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: bit 2 selects the lane, bits 1:0 select the register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
A capture and a software rearm can land on the same clock edge, and that collision is the delicate point. The bench drives a status write with bit 16 set in the same cycle as a strobe, once with the buffer full and once with it empty. It expects the first case to leave an empty buffer with the old time still readable, and the second to hold the new capture. Random traffic then mixes strobes on both lanes with rearm and enable writes, often in the same cycle. After every cycle, all eight registers are compared with a bench model built from the requirements.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
  localparam int REG_W     = 32;
  localparam int SEQ_W     = 16;
  localparam int HELD_BIT  = 16;
  localparam int EN_W      = 3;
  localparam int TIME_W    = 64;
  localparam int N_DIR     = 2;
  localparam int OFF_W     = 2;
  localparam int ADDR_W    = 3;

  typedef enum logic [OFF_W-1:0] {
    REG_STATUS  = 2'd0,
    REG_TIME_LO = 2'd1,
    REG_TIME_HI = 2'd2,
    REG_ENABLE  = 2'd3
  } reg_off_e;

  // Status word: held flag at HELD_BIT, sequence identifier in the low bits.
  function automatic logic [REG_W-1:0] pack_status(input logic held,
                                                   input logic [SEQ_W-1:0] seq);
    logic [REG_W-1:0] w;
    w = '0;
    w[SEQ_W-1:0] = seq;
    w[HELD_BIT]  = held;
    return w;
  endfunction

  // A status write rearms the buffer only when the held bit is written as one.
  function automatic logic is_rearm(input logic [REG_W-1:0] wdata);
    return wdata[HELD_BIT];
  endfunction

  // Any nonzero enable field lets capture happen.
  function automatic logic lane_enabled(input logic [EN_W-1:0] en);
    return |en;
  endfunction
endpackage

// File: rtl/tscap_decode.sv
module tscap_decode
  import tscap_pkg::*;
#(
  parameter int NDIR = N_DIR,
  parameter int AW   = ADDR_W,
  parameter int OW   = OFF_W,
  parameter int RW   = REG_W,
  parameter int EW   = EN_W
) (
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [RW-1:0]   wdata,
  output logic [NDIR-1:0] rearm_wr,
  output logic [NDIR-1:0] enable_wr,
  output logic [EW-1:0]   enable_val,
  output logic [AW-OW-1:0] dir_sel,
  output logic [OW-1:0]   off_sel
);
  localparam int DW = AW - OW;

  assign dir_sel    = addr[AW-1:OW];
  assign off_sel    = addr[OW-1:0];
  assign enable_val = wdata[EW-1:0];

  logic rearm_req;
  assign rearm_req = is_rearm(wdata);

  for (genvar d = 0; d < NDIR; d++) begin : g_lane
    logic lane_hit;
    assign lane_hit     = wr && (dir_sel == DW'(d));
    assign rearm_wr[d]  = lane_hit && (off_sel == REG_STATUS) && rearm_req;
    assign enable_wr[d] = lane_hit && (off_sel == REG_ENABLE);
  end
endmodule

// File: rtl/tscap_slot.sv
module tscap_slot
  import tscap_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int SW = SEQ_W,
  parameter int EW = EN_W,
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          evt,
  input  logic [SW-1:0] seq_in,
  input  logic          rearm_wr,
  input  logic          enable_wr,
  input  logic [EW-1:0] enable_val,
  output logic [RW-1:0] status_word,
  output logic [RW-1:0] time_lo,
  output logic [RW-1:0] time_hi,
  output logic [RW-1:0] enable_word,
  output logic          cap_o,
  output logic          clr_o,
  output logic          held_o,
  output logic [TW-1:0] time_o,
  output logic [SW-1:0] seq_o,
  output logic [EW-1:0] en_o
);
  logic [EW-1:0] en_q;
  logic          held_q;
  logic [SW-1:0] seq_q;
  logic [TW-1:0] time_q;

  // Capture only into an empty buffer; rearm only empties a full one.
  assign cap_o = evt && lane_enabled(en_q) && !held_q;
  assign clr_o = rearm_wr && held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      seq_q  <= '0;
      time_q <= '0;
    end else if (cap_o) begin
      held_q <= 1'b1;
      seq_q  <= seq_in;
      time_q <= time_now;
    end else if (clr_o) begin
      held_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (enable_wr) en_q <= enable_val;
  end

  assign status_word = pack_status(held_q, seq_q);
  assign time_lo     = time_q[RW-1:0];
  assign time_hi     = time_q[TW-1:RW];
  assign enable_word = RW'(en_q);
  assign held_o      = held_q;
  assign time_o      = time_q;
  assign seq_o       = seq_q;
  assign en_o        = en_q;
endmodule

// File: rtl/tscap_readmux.sv
module tscap_readmux
  import tscap_pkg::*;
#(
  parameter int NDIR = N_DIR,
  parameter int RW   = REG_W,
  parameter int OW   = OFF_W,
  parameter int DW   = ADDR_W - OFF_W
) (
  input  logic [NDIR-1:0][RW-1:0] status_w,
  input  logic [NDIR-1:0][RW-1:0] tlo_w,
  input  logic [NDIR-1:0][RW-1:0] thi_w,
  input  logic [NDIR-1:0][RW-1:0] en_w,
  input  logic [DW-1:0]           dir_sel,
  input  logic [OW-1:0]           off_sel,
  output logic [RW-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int d = 0; d < NDIR; d++) begin
      if (dir_sel == DW'(d)) begin
        case (off_sel)
          REG_STATUS:  rdata = status_w[d];
          REG_TIME_LO: rdata = tlo_w[d];
          REG_TIME_HI: rdata = thi_w[d];
          default:     rdata = en_w[d];
        endcase
      end
    end
  end
endmodule

// File: rtl/ts_capture_pair.sv
module ts_capture_pair
  import tscap_pkg::*;
#(
  parameter int TIME_BITS = TIME_W,
  parameter int SEQ_BITS  = SEQ_W,
  parameter int EN_BITS   = EN_W,
  parameter int WORD_BITS = REG_W,
  parameter int ADDR_BITS = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TIME_BITS-1:0] time_now,
  input  logic                 rx_evt,
  input  logic [SEQ_BITS-1:0]  rx_seq,
  input  logic                 tx_evt,
  input  logic [SEQ_BITS-1:0]  tx_seq,
  input  logic                 reg_wr,
  input  logic [ADDR_BITS-1:0] reg_addr,
  input  logic [WORD_BITS-1:0] reg_wdata,
  output logic [WORD_BITS-1:0] reg_rdata
);
  localparam int NLANE = 2;
  localparam int DSEL  = ADDR_BITS - OFF_W;

  logic [NLANE-1:0]                evt_v;
  logic [NLANE-1:0][SEQ_BITS-1:0]  seq_v;
  logic [NLANE-1:0]                rearm_wr, enable_wr;
  logic [EN_BITS-1:0]              enable_val;
  logic [DSEL-1:0]                 dir_sel;
  logic [OFF_W-1:0]                off_sel;
  logic [NLANE-1:0][WORD_BITS-1:0] status_w, tlo_w, thi_w, en_w;

  // Named internal events for the bound checker.
  logic [NLANE-1:0]                cap_hit, clr_hit, held_flag;
  logic [NLANE-1:0][TIME_BITS-1:0] held_time;
  logic [NLANE-1:0][SEQ_BITS-1:0]  held_seq;
  logic [NLANE-1:0][EN_BITS-1:0]   lane_en;

  assign evt_v = {tx_evt, rx_evt};
  assign seq_v = {tx_seq, rx_seq};

  tscap_decode #(
    .NDIR(NLANE), .AW(ADDR_BITS), .OW(OFF_W), .RW(WORD_BITS), .EW(EN_BITS)
  ) u_dec (
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rearm_wr(rearm_wr), .enable_wr(enable_wr), .enable_val(enable_val),
    .dir_sel(dir_sel), .off_sel(off_sel)
  );

  for (genvar d = 0; d < NLANE; d++) begin : g_slot
    tscap_slot #(
      .TW(TIME_BITS), .SW(SEQ_BITS), .EW(EN_BITS), .RW(WORD_BITS)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .time_now(time_now),
      .evt(evt_v[d]), .seq_in(seq_v[d]),
      .rearm_wr(rearm_wr[d]), .enable_wr(enable_wr[d]), .enable_val(enable_val),
      .status_word(status_w[d]), .time_lo(tlo_w[d]), .time_hi(thi_w[d]),
      .enable_word(en_w[d]),
      .cap_o(cap_hit[d]), .clr_o(clr_hit[d]), .held_o(held_flag[d]),
      .time_o(held_time[d]), .seq_o(held_seq[d]), .en_o(lane_en[d])
    );
  end

  tscap_readmux #(
    .NDIR(NLANE), .RW(WORD_BITS), .OW(OFF_W), .DW(DSEL)
  ) u_rd (
    .status_w(status_w), .tlo_w(tlo_w), .thi_w(thi_w), .en_w(en_w),
    .dir_sel(dir_sel), .off_sel(off_sel), .rdata(reg_rdata)
  );
endmodule

// File: rtl/tscap_checker.sv
module tscap_checker #(
  parameter int NL = 2,
  parameter int TW = 64,
  parameter int SW = 16,
  parameter int EW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [TW-1:0]         time_now,
  input logic [NL-1:0]         evt,
  input logic [NL-1:0]         cap,
  input logic [NL-1:0]         clr,
  input logic [NL-1:0]         held,
  input logic [NL-1:0][TW-1:0] held_time,
  input logic [NL-1:0][SW-1:0] held_seq,
  input logic [NL-1:0][EW-1:0] lane_en
);
  for (genvar d = 0; d < NL; d++) begin : g_chk
    // R2: a disabled lane never captures.
    a_r2_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_en[d] == '0) |-> !cap[d]);
    // R3: a capture sets the held flag on the next clock.
    a_r3_held_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap[d] |=> held[d]);
    // R3: the held time equals the time input of the strobe cycle.
    a_r3_time_sampled: assert property (@(posedge clk) disable iff (!rst_n)
      cap[d] |=> (held_time[d] == $past(time_now)));
    // R4: a full buffer keeps its contents while no rearm arrives.
    a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (held[d] && !clr[d]) |=> (held[d] && $stable(held_time[d]) && $stable(held_seq[d])));
    // R5: a rearm empties the buffer.
    a_r5_rearm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr[d] |=> !held[d]);
    // R6: a strobe on a full buffer is dropped even when a rearm lands with it.
    a_r6_collision_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (held[d] && evt[d] && clr[d]) |=> (!held[d] && $stable(held_time[d])));
  end
endmodule

bind ts_capture_pair tscap_checker #(
  .NL(2), .TW(TIME_BITS), .SW(SEQ_BITS), .EW(EN_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .time_now(time_now), .evt(evt_v),
  .cap(cap_hit), .clr(clr_hit), .held(held_flag),
  .held_time(held_time), .held_seq(held_seq), .lane_en(lane_en)
);

// File: tb/sim_ts_capture_pair.sv
`timescale 1ns/100ps
module sim_ts_capture_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        rx_evt = 1'b0, tx_evt = 1'b0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench model of both lanes, built from the requirements.
  logic        m_held [2];
  logic [63:0] m_time [2];
  logic [15:0] m_seq  [2];
  logic [2:0]  m_en   [2];

  always #2.5 clk = ~clk;

  ts_capture_pair u0 (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .rx_evt(rx_evt), .rx_seq(rx_seq), .tx_evt(tx_evt), .tx_seq(tx_seq),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // Register value per R3, R8, R9: offset 0 status, 1 time low, 2 time high, 3 enable.
  function automatic logic [31:0] expect_word(input logic [2:0] a);
    int d = int'(a[2]);
    case (a[1:0])
      2'd0:    return {15'd0, m_held[d], m_seq[d]};
      2'd1:    return m_time[d][31:0];
      2'd2:    return m_time[d][63:32];
      default: return {29'd0, m_en[d]};
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reads all eight registers after a clock edge, with the write strobe low.
  task automatic check_all(input string tag);
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #0.2;
      check(reg_rdata, expect_word(3'(a)), $sformatf("%s addr%0d", tag, a));
    end
  endtask

  task automatic read_now(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.2;
    v = reg_rdata;
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge.
  task automatic step(input logic [1:0] ev, input logic [63:0] t,
                      input logic [15:0] s0, input logic [15:0] s1,
                      input logic w, input logic [2:0] a, input logic [31:0] wd,
                      input string tag);
    logic [15:0] sv [2];
    @(negedge clk);
    rx_evt = ev[0]; tx_evt = ev[1]; time_now = t; rx_seq = s0; tx_seq = s1;
    reg_wr = w; reg_addr = a; reg_wdata = wd;
    sv[0] = s0; sv[1] = s1;
    @(posedge clk);
    for (int d = 0; d < 2; d++) begin
      logic hit = w && (int'(a[2]) == d);
      logic rearm = hit && (a[1:0] == 2'd0) && wd[16];
      if (m_held[d]) begin
        if (rearm) m_held[d] = 1'b0;
      end else if (ev[d] && (m_en[d] != 3'd0)) begin
        m_held[d] = 1'b1; m_time[d] = t; m_seq[d] = sv[d];
      end
      if (hit && a[1:0] == 2'd3) m_en[d] = wd[2:0];
    end
    #0.5;
    rx_evt = 1'b0; tx_evt = 1'b0; reg_wr = 1'b0;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b0, 3'd0, 32'd0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_0042));
    for (int d = 0; d < 2; d++) begin
      m_held[d] = 1'b0; m_time[d] = '0; m_seq[d] = '0; m_en[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2: disabled lane ignores a strobe.
    step(2'b01, 64'h1111_2222_3333_4444, 16'hA1A1, 16'h0, 1'b0, 3'd0, 32'd0, "R2 disabled rx");
    read_now(3'd0, v); check(v, 32'd0, "R2 rx status after disabled strobe");

    // R8: enable value 5 on rx, 2 on tx, upper write bits dropped.
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd3, 32'hFFFF_FFF5, "R8 rx enable write");
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd7, 32'h0000_0002, "R8 tx enable write");
    read_now(3'd3, v); check(v, 32'd5, "R8 rx enable readback");

    // R3: capture, held flag and sequence visible after the next clock.
    step(2'b01, 64'h0123_4567_89AB_CDEF, 16'hBEEF, 16'h0, 1'b0, 3'd0, 32'd0, "R3 rx capture");
    read_now(3'd0, v); check(v, 32'h0001_BEEF, "R3 rx status");
    read_now(3'd1, v); check(v, 32'h89AB_CDEF, "R3 rx time low");
    read_now(3'd2, v); check(v, 32'h0123_4567, "R3 rx time high");

    // R4: second strobe dropped.
    step(2'b01, 64'hFFFF_0000_FFFF_0000, 16'h1234, 16'h0, 1'b0, 3'd0, 32'd0, "R4 drop while full");
    read_now(3'd1, v); check(v, 32'h89AB_CDEF, "R4 rx time unchanged");

    // R9: writes to time registers ignored.
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd1, 32'h5555_5555, "R9 time low write");
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd2, 32'h5555_5555, "R9 time high write");

    // R5: status write with bit 16 clear does nothing, with bit 16 set empties.
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd0, 32'hFFFE_FFFF, "R5 no rearm");
    read_now(3'd0, v); check(v, 32'h0001_BEEF, "R5 still held");
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd0, 32'h0001_0000, "R5 rearm");
    read_now(3'd0, v); check(v[16], 1'b0, "R5 held cleared");

    // R6: collision on an empty buffer captures.
    step(2'b01, 64'hAAAA_0000_0000_0001, 16'h0777, 16'h0, 1'b1, 3'd0, 32'h0001_0000, "R6 empty collision");
    read_now(3'd0, v); check(v, 32'h0001_0777, "R6 empty collision captured");
    // R6: collision on a full buffer drops and empties.
    step(2'b01, 64'hBBBB_0000_0000_0002, 16'h0888, 16'h0, 1'b1, 3'd0, 32'h0001_0000, "R6 full collision");
    read_now(3'd0, v); check(v[16], 1'b0, "R6 full collision emptied");
    read_now(3'd1, v); check(v, 32'h0000_0001, "R6 old time kept");

    // R7: tx capture leaves rx alone, rx rearm leaves tx alone.
    step(2'b10, 64'hCAFE_F00D_1234_5678, 16'h0, 16'h4242, 1'b0, 3'd0, 32'd0, "R7 tx capture");
    read_now(3'd4, v); check(v, 32'h0001_4242, "R7 tx status");
    read_now(3'd0, v); check(v[16], 1'b0, "R7 rx untouched");
    step(2'b00, 64'd0, 16'd0, 16'd0, 1'b1, 3'd0, 32'h0001_0000, "R7 rx rearm only");
    read_now(3'd4, v); check(v[16], 1'b1, "R7 tx still held");
    idle("R1 idle");

    // Random traffic on both lanes with writes mixed in.
    for (int i = 0; i < 2000; i++) begin
      logic [1:0]  ev = 2'($urandom_range(0, 3));
      logic [63:0] t  = {$urandom(), $urandom()};
      logic        w  = ($urandom_range(0, 2) == 0);
      logic [2:0]  a  = 3'($urandom_range(0, 7));
      logic [31:0] wd = $urandom();
      if ($urandom_range(0, 1) == 1) wd[16] = 1'b1;
      if (a[1:0] == 2'd3 && $urandom_range(0, 3) == 0) wd[2:0] = 3'd0;
      step(ev, t, 16'($urandom()), 16'($urandom()), w, a, wd, "R3/R4/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule